// File: doc/BRIEF.md
# Mailbox Event Status Register

This block is the slave-side status register of a block-transfer mailbox. A host moves bytes through a data buffer backed by a FIFO. Two of the host's actions leave a sticky mark that the slave CPU can see. The first is writing a byte while the FIFO is already full, which asks the slave to drain the FIFO. The second is reading a byte from the buffer. The slave CPU sees both marks through one 8-bit register on a simple select/write-enable bus. It also gets a single interrupt request, gated by per-flag enables and a master enable.

Clearing is guarded against races. A flag drops only when the slave writes 0 to it, and only after an earlier slave read returned that flag as 1. Each flag has a hidden "armed" bit that remembers such a read. A new host event in the cycle of a valid clear keeps the flag set. The FIFO, the host bus decoding and the enable register sit outside the block and appear only as input pins.

Top module: `evt_status_reg`

## Requirements
- R1: After reset, every bit of `cpu_rdata` is 0 and `irq_req` is 0.
- R2: A cycle with `host_wr_stb`=1 and `fifo_full`=1 sets the drain-request flag at bit 4. A host write with `fifo_full`=0 leaves bit 4 unchanged.
- R3: A cycle with `host_rd_stb`=1 sets the host-read flag at bit 3.
- R4: A slave write (`cpu_cs`=1, `cpu_we`=1) with a 0 in a flag's bit position clears that flag only if a slave read (`cpu_cs`=1, `cpu_we`=0) has returned it as 1 since it last cleared. Otherwise the flag stays at 1.
- R5: A slave write with a 1 in a flag's bit position never changes that flag.
- R6: If a flag's set event and a valid clear fall in the same cycle, the flag stays at 1.
- R7: Bits 7 to 5 and 2 to 0 always read as 0, and slave writes to them have no effect.
- R8: `irq_req` is a registered level. At clock edge k it takes the value `irq_master_en & ((bit4 & irq_full_en) | (bit3 & irq_rd_en))`, using the flag and enable values in place just before that edge.
- R9: A flag loses its armed state when it clears. After a clear and a new set, a write of 0 with no intervening read leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_stb | input | 1 | Host writes one byte to the data buffer this cycle |
| host_rd_stb | input | 1 | Host reads one byte from the data buffer this cycle |
| fifo_full | input | 1 | Data FIFO is full |
| cpu_cs | input | 1 | Slave access to this register this cycle |
| cpu_we | input | 1 | 1 = slave write, 0 = slave read |
| cpu_wdata | input | 8 | Slave write data |
| cpu_rdata | output | 8 | Current register value |
| irq_master_en | input | 1 | Master interrupt enable |
| irq_full_en | input | 1 | Enable for the drain-request flag |
| irq_rd_en | input | 1 | Enable for the host-read flag |
| irq_req | output | 1 | Combined interrupt request |

## Verification
Each flag is a single register. A host event or slave write that is driven before clock edge k therefore appears on `cpu_rdata` right after edge k. The interrupt adds one more register, so its effect on `irq_req` shows after edge k+1. The bench drives every input at the falling edge and samples one time unit after the rising edge. For each cycle it predicts the interrupt from the model state and enables held before that edge, and it predicts the register value after the model has applied the cycle's events. Constrained random traffic is interleaved with directed sequences that cover clearing without arming, write-1, set-versus-clear collisions, loss of the armed state and reserved bits.

// File: rtl/evt_stat_pkg.sv
package evt_stat_pkg;
   // event slots, index order also fixes bit order above FLAG_LSB
   localparam int HRD_IDX = 0;   // host read a byte
   localparam int FRQ_IDX = 1;   // host wrote while FIFO full
   localparam int NUM_EVT = 2;

   typedef logic [NUM_EVT-1:0] evt_vec_t;
endpackage

// File: rtl/evt_flag_cell.sv
module evt_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic rd_i,
   input  logic wr_i,
   input  logic wbit_i,
   output logic flag_o
);
   logic flag_q;
   logic armed_q;
   logic clr_ok;

   assign clr_ok = wr_i & ~wbit_i & armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (set_i)
            flag_q <= 1'b1;
         else if (clr_ok)
            flag_q <= 1'b0;

         if (clr_ok && !set_i)
            armed_q <= 1'b0;
         else if (rd_i && flag_q)
            armed_q <= 1'b1;
      end
   end

   assign flag_o = flag_q;

   // R2
   set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_q);
   // R4
   clear_needs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(wr_i && !wbit_i));
   // R4
   clear_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(armed_q));
   // R5
   write_one_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && wr_i && wbit_i) |=> flag_q);
   // R6
   set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && clr_ok) |=> (flag_q && armed_q));
endmodule

// File: rtl/evt_irq_gen.sv
module evt_irq_gen #(
   parameter int NUM      = 2,
   parameter bit SYNC_IRQ = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           master_en_i,
   input  logic [NUM-1:0] flags_i,
   input  logic [NUM-1:0] ens_i,
   output logic           irq_o
);
   logic hit;

   always_comb hit = master_en_i & (|(flags_i & ens_i));

   generate
      if (SYNC_IRQ) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= hit;
         end
         assign irq_o = irq_q;

         // R8
         irq_needs_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o |-> $past(master_en_i));
         // R8
         irq_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o |-> $past(|(flags_i & ens_i)));
      end else begin : g_comb
         assign irq_o = hit;
      end
   endgenerate
endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg
   import evt_stat_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int FLAG_LSB = 3,
   parameter bit SYNC_IRQ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr_stb,
   input  logic              host_rd_stb,
   input  logic              fifo_full,
   input  logic              cpu_cs,
   input  logic              cpu_we,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              irq_master_en,
   input  logic              irq_full_en,
   input  logic              irq_rd_en,
   output logic              irq_req
);
   localparam int FLAG_MSB = FLAG_LSB + NUM_EVT - 1;

   generate
      if (FLAG_MSB >= DATA_W) begin : g_bad_width
         $error("flag field does not fit in DATA_W");
      end
   endgenerate

   evt_vec_t set_vec;
   evt_vec_t flags;
   evt_vec_t ens;
   logic     slv_rd;
   logic     slv_wr;
   logic     unused_wbits;

   assign slv_rd = cpu_cs & ~cpu_we;
   assign slv_wr = cpu_cs &  cpu_we;
   assign unused_wbits = ^cpu_wdata;

   always_comb begin
      set_vec          = '0;
      set_vec[HRD_IDX] = host_rd_stb;
      set_vec[FRQ_IDX] = host_wr_stb & fifo_full;
      ens              = '0;
      ens[HRD_IDX]     = irq_rd_en;
      ens[FRQ_IDX]     = irq_full_en;
   end

   generate
      for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
         evt_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[i]),
            .rd_i   (slv_rd),
            .wr_i   (slv_wr),
            .wbit_i (cpu_wdata[FLAG_LSB+i]),
            .flag_o (flags[i])
         );
      end
   endgenerate

   always_comb begin
      cpu_rdata                       = '0;
      cpu_rdata[FLAG_LSB +: NUM_EVT]  = flags;
   end

   evt_irq_gen #(
      .NUM      (NUM_EVT),
      .SYNC_IRQ (SYNC_IRQ)
   ) u_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .master_en_i (irq_master_en),
      .flags_i     (flags),
      .ens_i       (ens),
      .irq_o       (irq_req)
   );

   // R2
   frq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[FRQ_IDX]) |-> $past(host_wr_stb && fifo_full));
   // R3
   hrd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[HRD_IDX]) |-> $past(host_rd_stb));
endmodule

// File: tb/test_evt_status_reg.sv
module test_evt_status_reg;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr_stb = 1'b0, host_rd_stb = 1'b0, fifo_full = 1'b0;
   logic       cpu_cs = 1'b0, cpu_we = 1'b0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic       irq_master_en = 1'b0, irq_full_en = 1'b0, irq_rd_en = 1'b0;
   logic       irq_req;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  done     = 1'b0;

   // model state: index 0 = bit 3 (host read), index 1 = bit 4 (drain request)
   logic mf [2];
   logic ma [2];

   always #(CLK_PERIOD/2) clk = ~clk;

   evt_status_reg i_evt_status_reg (
      .clk           (clk),
      .rst_n         (rst_n),
      .host_wr_stb   (host_wr_stb),
      .host_rd_stb   (host_rd_stb),
      .fifo_full     (fifo_full),
      .cpu_cs        (cpu_cs),
      .cpu_we        (cpu_we),
      .cpu_wdata     (cpu_wdata),
      .cpu_rdata     (cpu_rdata),
      .irq_master_en (irq_master_en),
      .irq_full_en   (irq_full_en),
      .irq_rd_en     (irq_rd_en),
      .irq_req       (irq_req)
   );

   function automatic logic [7:0] exp_reg();
      return {3'b000, mf[1], mf[0], 3'b000};
   endfunction

   function automatic logic exp_irq(input logic me, input logic e_full, input logic e_rd);
      return me & ((mf[1] & e_full) | (mf[0] & e_rd));
   endfunction

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: rdata actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check1(input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: irq actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic hw, input logic hr, input logic ff,
                      input logic cs, input logic we, input logic [7:0] wd,
                      input logic me, input logic e_full, input logic e_rd,
                      input string tag);
      logic ei;
      logic st [2];
      @(negedge clk);
      host_wr_stb = hw; host_rd_stb = hr; fifo_full = ff;
      cpu_cs = cs; cpu_we = we; cpu_wdata = wd;
      irq_master_en = me; irq_full_en = e_full; irq_rd_en = e_rd;
      ei = exp_irq(me, e_full, e_rd);
      st[0] = hr;
      st[1] = hw & ff;
      for (int i = 0; i < 2; i++) begin
         logic clr;
         clr = cs & we & ~wd[3+i] & ma[i];
         if (clr && !st[i])       ma[i] = 1'b0;
         else if (cs && !we && mf[i]) ma[i] = 1'b1;
         mf[i] = st[i] | (mf[i] & ~clr);
      end
      @(posedge clk);
      #1;
      check8(tag, cpu_rdata, exp_reg());
      check1("R8", irq_req, ei);
   endtask

   // shorthand with all interrupt enables on
   task automatic op(input logic hw, input logic hr, input logic ff,
                     input logic cs, input logic we, input logic [7:0] wd, input string tag);
      cyc(hw, hr, ff, cs, we, wd, 1'b1, 1'b1, 1'b1, tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      for (int i = 0; i < 2; i++) begin mf[i] = 1'b0; ma[i] = 1'b0; end
      repeat (3) @(posedge clk);
      #1;
      check8("R1", cpu_rdata, 8'h00);
      check1("R1", irq_req, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      op(0,0,0, 0,0,8'h00, "R1");

      // R2: write while not full does nothing, while full sets bit 4
      op(1,0,0, 0,0,8'h00, "R2");
      op(1,0,1, 0,0,8'h00, "R2");
      op(0,0,0, 0,0,8'h00, "R8");
      // R4: write 0 without a prior read leaves it
      op(0,0,0, 1,1,8'h00, "R4");
      // read arms, write 1 ignored, write 0 clears
      op(0,0,0, 1,0,8'h00, "R4");
      op(0,0,0, 1,1,8'hFF, "R5");
      op(0,0,0, 1,1,8'h00, "R4");
      // R3 and R6: set collides with a valid clear
      op(0,1,0, 0,0,8'h00, "R3");
      op(0,0,0, 1,0,8'h00, "R3");
      op(0,1,0, 1,1,8'h00, "R6");
      op(0,0,0, 1,1,8'h00, "R6");
      // R9: after a clear the armed state is gone
      op(0,1,0, 0,0,8'h00, "R9");
      op(0,0,0, 1,0,8'h00, "R9");
      op(0,0,0, 1,1,8'h00, "R9");
      op(0,1,0, 0,0,8'h00, "R9");
      op(0,0,0, 1,1,8'h00, "R9");
      // R7: reserved bits
      op(0,0,0, 1,1,8'hE7, "R7");
      op(0,0,0, 1,0,8'h00, "R7");
      // R8: enable gating
      op(1,0,1, 0,0,8'h00, "R8");
      cyc(0,0,0, 0,0,8'h00, 1'b0,1'b1,1'b1, "R8");
      cyc(0,0,0, 0,0,8'h00, 1'b1,1'b0,1'b1, "R8");
      cyc(0,0,0, 0,0,8'h00, 1'b1,1'b1,1'b0, "R8");
      cyc(0,0,0, 0,0,8'h00, 1'b1,1'b0,1'b0, "R8");

      for (int n = 0; n < 4000; n++) begin
         logic cs, we;
         cs = ($urandom % 100) < 35;
         we = $urandom % 2;
         cyc(($urandom % 8) == 0, ($urandom % 8) == 0, $urandom % 2,
             cs, we, 8'($urandom),
             ($urandom % 4) != 0, $urandom % 2, $urandom % 2,
             "R4/R5/R6 random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule